// File: doc/BRIEF.md
# Sub-dword destination result merger

This block sits after the vector ALU. Each lane has a 32-bit result. The block writes the low byte or the low halfword of that result into one chosen byte or halfword slot of the destination word. The rest of the destination word is then filled by one of three rules:

- zero fill;
- sign fill above the slot, with zeros below it;
- keeping the previous destination contents.

A full-word position code writes the whole result unchanged. Every lane shares one set of controls: a 3-bit position code and a 2-bit fill mode. Each lane has its own new and old data. The merged vector is registered and comes out one cycle later with a valid flag. Control combinations that are not defined also come out one cycle later: they return the old destination unchanged and raise an error flag.

Top module: `sdm_merge`

## Requirements
- R1: While reset is held, and right after it, `out_valid`, `out_err` and `out_data` are all zero.
- R2: Position codes 0 to 3 (with a legal mode) place `res` bits 7:0 into destination byte 0 to 3, at bits 8*code+7 down to 8*code.
- R3: Position code 4 places `res` bits 15:0 into destination bits 15:0. Position code 5 places them into bits 31:16.
- R4: Position code 6 with fill mode 0, 1 or 2 writes all 32 result bits unchanged. The fill mode has no effect.
- R5: Fill mode 0 makes every bit outside the placed slot zero.
- R6: Fill mode 1 fills bytes or halfwords above the slot with ones when the sign bit is 1, and with zeros when it is 0. The sign bit is bit 7 of the placed field for codes 0 to 3 and bit 15 for codes 4 and 5. Bits below the slot are zero.
- R7: Fill mode 2 copies the old destination value into every bit outside the slot.
- R8: Fill mode 3 or position code 7 is illegal, and this takes precedence over code 6. For an illegal request `out_data` equals the old destination vector and `out_err` is 1. For a legal request `out_err` is 0.
- R9: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `out_data` keeps its last value and `out_err` is 0.
- R10: All lanes use the same controls but merge their own data independently. Lane i occupies bits 32*i+31 down to 32*i of every vector port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| pos_sel | input | 3 | Slot code: 0-3 byte, 4-5 halfword, 6 full word, 7 illegal |
| fill_mode | input | 2 | 0 zero fill, 1 sign fill upward, 2 keep old, 3 illegal |
| res_vec | input | 32*LANES | New ALU result per lane |
| old_vec | input | 32*LANES | Previous destination contents per lane |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 32*LANES | Merged destination per lane |
| out_err | output | 1 | Illegal control combination seen |

## Verification
Two decisions can apply in the same cycle:

- the full-word write for code 6;
- the illegal-combination path for mode 3.

Both apply when code 6 arrives together with mode 3. The bench sweeps every pairing of position code and fill mode, so this collision is always provoked. It is judged by expecting the old destination and a raised error rather than the new result.

Sign fill is also driven with opposite signs in different lanes in the same cycle, which shows that the fill decision is made per lane even though the controls are shared.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;

  typedef enum logic [1:0] {BSRC_RES, BSRC_OLD, BSRC_ZERO, BSRC_SIGN} bsrc_e;

  typedef struct packed {
    bsrc_e      kind;
    logic [1:0] idx;
  } bplan_t;

  // True when the control pair is outside the defined set.
  function automatic logic is_illegal(input logic [2:0] sel, input logic [1:0] mode);
    return (mode == 2'd3) || (sel == 3'd7);
  endfunction

  // Decide where destination byte k comes from.
  function automatic bplan_t plan_byte(input logic [1:0] k, input logic [2:0] sel,
                                       input logic [1:0] mode);
    bplan_t p;
    p.kind = BSRC_ZERO;
    p.idx  = k;
    if (is_illegal(sel, mode)) begin
      p.kind = BSRC_OLD;
    end else if (sel == 3'd6) begin
      p.kind = BSRC_RES;
    end else if (!sel[2]) begin
      if ({1'b0, k} == sel) begin
        p.kind = BSRC_RES;
        p.idx  = 2'd0;
      end else if (mode == 2'd2) begin
        p.kind = BSRC_OLD;
      end else if (mode == 2'd1 && {1'b0, k} > sel) begin
        p.kind = BSRC_SIGN;
      end
    end else begin
      if (k[1] == sel[0]) begin
        p.kind = BSRC_RES;
        p.idx  = {1'b0, k[0]};
      end else if (mode == 2'd2) begin
        p.kind = BSRC_OLD;
      end else if (mode == 2'd1 && k[1] > sel[0]) begin
        p.kind = BSRC_SIGN;
      end
    end
    return p;
  endfunction

  // Produce one destination byte from its plan.
  function automatic logic [7:0] pick_byte(input bplan_t p, input logic [WORD_W-1:0] res,
                                           input logic [7:0] old_b, input logic sign);
    logic [7:0] v;
    case (p.kind)
      BSRC_RES:  v = res[8*p.idx +: 8];
      BSRC_OLD:  v = old_b;
      BSRC_SIGN: v = {8{sign}};
      default:   v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sdm_ctrl_decode.sv
module sdm_ctrl_decode
  import sdm_pkg::*;
(
  input  logic [2:0]             pos_sel,
  input  logic [1:0]             fill_mode,
  output bplan_t [BYTES-1:0]     plan,
  output logic                   illegal,
  output logic                   half_sign
);
  assign illegal   = is_illegal(pos_sel, fill_mode);
  assign half_sign = pos_sel[2];

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign plan[k] = plan_byte(k[1:0], pos_sel, fill_mode);
  end
endmodule

// File: rtl/sdm_lane_merge.sv
module sdm_lane_merge
  import sdm_pkg::*;
(
  input  bplan_t [BYTES-1:0]     plan,
  input  logic                   half_sign,
  input  logic [WORD_W-1:0]      res,
  input  logic [WORD_W-1:0]      old,
  output logic [WORD_W-1:0]      merged
);
  logic sign_bit;
  assign sign_bit = half_sign ? res[15] : res[7];

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign merged[8*k +: 8] = pick_byte(plan[k], res, old[8*k +: 8], sign_bit);
  end
endmodule

// File: rtl/sdm_merge.sv
module sdm_merge
  import sdm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                pos_sel,
  input  logic [1:0]                fill_mode,
  input  logic [LANES*WORD_W-1:0]   res_vec,
  input  logic [LANES*WORD_W-1:0]   old_vec,
  output logic                      out_valid,
  output logic [LANES*WORD_W-1:0]   out_data,
  output logic                      out_err
);
  localparam int VEC_W = LANES * WORD_W;

  bplan_t [BYTES-1:0] plan;
  logic               illegal;
  logic               half_sign;
  logic [VEC_W-1:0]   merged_vec;

  sdm_ctrl_decode u_dec (
    .pos_sel   (pos_sel),
    .fill_mode (fill_mode),
    .plan      (plan),
    .illegal   (illegal),
    .half_sign (half_sign)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sdm_lane_merge u_lane (
      .plan      (plan),
      .half_sign (half_sign),
      .res       (res_vec[i*WORD_W +: WORD_W]),
      .old       (old_vec[i*WORD_W +: WORD_W]),
      .merged    (merged_vec[i*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && illegal;
      if (in_valid) out_data <= merged_vec;
    end
  end
endmodule

// File: rtl/sdm_merge_checker.sv
module sdm_merge_checker #(
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [2:0]            pos_sel,
  input logic [1:0]            fill_mode,
  input logic [LANES*32-1:0]   res_vec,
  input logic [LANES*32-1:0]   old_vec,
  input logic                  out_valid,
  input logic [LANES*32-1:0]   out_data,
  input logic                  out_err
);
  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err && $stable(out_data)));
  p_err_keeps_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (fill_mode == 2'd3 || pos_sel == 3'd7)) |=>
      (out_err && out_data == $past(old_vec)));
  p_full_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_sel == 3'd6 && fill_mode != 2'd3) |=>
      (!out_err && out_data == $past(res_vec)));
  p_zero_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_sel == 3'd3 && fill_mode == 2'd0) |=>
      (out_data[23:0] == 24'h0 && out_data[31:24] == $past(res_vec[7:0])));
  p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_sel == 3'd0 && fill_mode == 2'd1 && res_vec[7]) |=>
      (out_data[31:8] == 24'hFFFFFF));
  p_keep_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_sel == 3'd5 && fill_mode == 2'd2) |=>
      (out_data[15:0] == $past(old_vec[15:0]) && out_data[31:16] == $past(res_vec[15:0])));
  p_err_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
endmodule

bind sdm_merge sdm_merge_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pos_sel   (pos_sel),
  .fill_mode (fill_mode),
  .res_vec   (res_vec),
  .old_vec   (old_vec),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/sdm_merge_bench.sv
`timescale 1ns/1ps
module sdm_merge_bench;
  localparam int LANES = 4;
  localparam int VW    = LANES * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    pos_sel = '0;
  logic [1:0]    fill_mode = '0;
  logic [VW-1:0] res_vec = '0;
  logic [VW-1:0] old_vec = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;
  logic          out_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdm_merge #(.LANES(LANES)) u_sdm_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pos_sel(pos_sel),
    .fill_mode(fill_mode), .res_vec(res_vec), .old_vec(old_vec),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  // Arithmetic model: masks built from slot width and offset.
  function automatic logic [31:0] model(input logic [31:0] r, input logic [31:0] o,
                                        input int sel, input int mode);
    longint w, pos, low, fmask, field, above;
    logic sgn;
    if (mode == 3 || sel == 7) return o;
    if (sel == 6) return r;
    w     = (sel < 4) ? 8 : 16;
    pos   = (sel < 4) ? sel * 8 : (sel - 4) * 16;
    low   = (longint'(1) << w) - 1;
    fmask = low << pos;
    field = (longint'(r) & low) << pos;
    sgn   = r[w-1];
    above = 64'hFFFF_FFFF & ~((longint'(1) << (pos + w)) - 1);
    case (mode)
      0: return field[31:0];
      1: return field[31:0] | (sgn ? above[31:0] : 32'h0);
      default: return field[31:0] | (o & ~fmask[31:0]);
    endcase
  endfunction

  function automatic string tag_of(input int sel, input int mode);
    if (mode == 3 || sel == 7) return "R8";
    if (sel == 6) return "R4";
    if (mode == 1) return "R6";
    if (mode == 2) return "R7";
    if (sel >= 4) return "R3/R5";
    return "R2/R5";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Apply one request at a negedge; compare the registered output one negedge later.
  task automatic run_one(input int sel, input int mode, input logic [VW-1:0] r, input logic [VW-1:0] o);
    logic [31:0] e;
    bit exp_err;
    in_valid  = 1'b1;
    pos_sel   = sel[2:0];
    fill_mode = mode[1:0];
    res_vec   = r;
    old_vec   = o;
    @(negedge clk);
    exp_err = (mode == 3 || sel == 7);
    chk(out_valid == 1'b1, "R9", {31'b0, out_valid}, 32'h1);
    chk(out_err == exp_err, "R8", {31'b0, out_err}, {31'b0, exp_err});
    for (int i = 0; i < LANES; i++) begin
      e = model(r[i*32 +: 32], o[i*32 +: 32], sel, mode);
      chk(out_data[i*32 +: 32] == e, tag_of(sel, mode), out_data[i*32 +: 32], e);
    end
  endtask

  initial begin
    logic [VW-1:0] pr [6];
    logic [VW-1:0] po [6];
    logic [VW-1:0] held;
    pr[0] = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_8080, 32'hFFFF_7F7F};
    po[0] = {32'hAAAA_5555, 32'h5555_AAAA, 32'hDEAD_BEEF, 32'h0000_0000};
    pr[1] = {32'h0000_0080, 32'h0000_007F, 32'h0000_8000, 32'h0000_7FFF};
    po[1] = {32'hFFFF_FFFF, 32'h0123_4567, 32'h89AB_CDEF, 32'hC3C3_3C3C};
    pr[2] = {32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'h7FFF_FFFE};
    po[2] = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888};
    pr[3] = {32'hCAFE_F00D, 32'h0BAD_C0DE, 32'hFEED_0180, 32'h00FF_FF00};
    po[3] = {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF};
    pr[4] = {32'h6B6B_8C8C, 32'h2468_ACE0, 32'h1357_9BDF, 32'hF00F_F0F0};
    po[4] = {32'h9999_9999, 32'h6666_6666, 32'hA5A5_A5A5, 32'h5A5A_5A5A};
    pr[5] = {32'h0000_FF00, 32'h00FF_0000, 32'hFF00_0000, 32'h0000_00FF};
    po[5] = {32'h8765_4321, 32'h1234_5678, 32'h0F1E_2D3C, 32'h4B5A_6978};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_err && out_data == '0, "R1", out_data[31:0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_err && out_data == '0, "R1", {30'b0, out_valid, out_err}, 32'h0);

    // Full sweep of position code x fill mode x data pattern (R2-R8, R10)
    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 4; m++)
          run_one(s, m, pr[p], po[p]);

    // R10: opposite signs across lanes under shared sign-fill controls
    run_one(0, 1, {32'h0000_0080, 32'h0000_0070, 32'h0000_00FF, 32'h0000_0001}, '0);
    chk(out_data[31:0] == 32'h0000_0001 && out_data[63:32] == 32'hFFFF_FFFF, "R10",
        out_data[63:32], 32'hFFFF_FFFF);

    // R9: idle cycle holds data, drops valid and error
    run_one(7, 0, pr[0], po[0]);
    held      = out_data;
    in_valid  = 1'b0;
    res_vec   = ~res_vec;
    old_vec   = ~old_vec;
    fill_mode = 2'd3;
    @(negedge clk);
    chk(!out_valid && !out_err, "R9", {30'b0, out_valid, out_err}, 32'h0);
    chk(out_data == held, "R9", out_data[31:0], held[31:0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule